// File: doc/BRIEF.md
# UART Receive Path with Idle Timeout and Flow Control

This block turns a serial line into bytes held in a receive FIFO and raises interrupt status for six conditions: FIFO level at or above a threshold, line idle with data waiting, bad stop bit, bad parity, line break, and a byte dropped because the FIFO was full. Every source has a raw status bit. The bit is set by hardware and cleared when software writes 1 to the matching clear bit. An enable mask then selects which raw bits reach the interrupt line.

The line is sampled 16 times per bit. The receiver takes a byte only after the stop bit has ended, so the FIFO count never includes a byte whose stop bit is still on the wire. The idle timeout counts in whole character times, where one unit is eight bit periods. A second FIFO threshold, separate from the interrupt threshold, drives a ready-to-receive output for the far end. A loopback input replaces the external line with a local transmit signal.

Top module: `uart_rx_irq`

## Requirements
- R1: One oversample tick occurs every `baud_div_i` clocks, and a bit lasts 16 ticks. A low level is accepted as a start bit only if it is still low at mid-bit, so a pulse shorter than half a bit is ignored. Data arrives LSB first. The data length code is 0 for 5 bits, 1 for 6, 2 for 7 and 3 for 8. An optional parity bit follows the data, then one stop bit. Bytes shorter than 8 bits are zero-extended in the FIFO.
- R2: `fifo_cnt_o` does not rise at mid-stop-bit. It rises only when the stop bit has ended.
- R3: A byte that arrives while the FIFO holds DEPTH entries is discarded, the stored contents are left unchanged, and status bit 5 (overflow) is set.
- R4: Status bit 0 (threshold) is set on every cycle in which the FIFO count is at or above a nonzero `full_thr_i`. Clearing it therefore takes effect only once the FIFO has been drained below that level.
- R5: Status bit 1 (timeout) is set when the FIFO is non-empty, the receiver is idle, and `tout_thr_i` × 8 bit times (128 ticks per unit) have passed since the last received byte. It is never set when `tout_en_i` is 0 or the FIFO is empty.
- R6: Status bit 3 (parity) is set when parity is enabled and the received parity bit mismatches. With `parity_odd_i` = 0 the data and parity bits must hold an even number of ones; with 1, an odd number. The byte is still stored.
- R7: Status bit 2 (frame) is set when the stop bit is sampled low and the frame is not a break. The byte is still stored.
- R8: When the start bit, all data bits, the parity bit and the stop bit are all low, status bit 4 (break) is set, no byte is stored, and no further break or byte is reported until the line returns high.
- R9: Writing 1 to a bit of `int_clr_i` clears the matching raw bit on the next clock; a set in the same cycle wins. `int_st_o` is `int_raw_o` & `int_ena_i`, and `irq_o` is the OR of `int_st_o`.
- R10: `rts_o` is 0 when `flow_en_i` is 1 and the FIFO count is at or above `flow_thr_i`. Otherwise it is 1.
- R11: After reset the FIFO is empty. Reads return bytes in arrival order. A one-cycle high pulse on `fifo_rst_i` empties the FIFO.
- R12: With `loopback_i` = 1 the receiver takes `lb_txd_i` as the line and ignores `rxd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd_i | input | 1 | External serial line |
| loopback_i | input | 1 | Select local transmit signal as line |
| lb_txd_i | input | 1 | Local transmit signal for loopback |
| baud_div_i | input | DIV_W | Clocks per oversample tick |
| data_bits_i | input | 2 | Data length code (5 + code bits) |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | Odd parity when 1 |
| fifo_rst_i | input | 1 | Empty the FIFO |
| rd_en_i | input | 1 | Pop the head byte |
| rd_data_o | output | 8 | Head byte of FIFO |
| fifo_cnt_o | output | CNT_W | FIFO occupancy |
| full_thr_i | input | CNT_W | Threshold interrupt level (0 disables) |
| flow_en_i | input | 1 | Enable flow-control output |
| flow_thr_i | input | CNT_W | Flow-control level |
| tout_en_i | input | 1 | Enable idle timeout status |
| tout_thr_i | input | TOUT_W | Timeout in units of 8 bit times |
| int_ena_i | input | 6 | Per-source interrupt enable |
| int_clr_i | input | 6 | Write-1-to-clear strobes |
| int_raw_o | output | 6 | Raw status bits |
| int_st_o | output | 6 | Masked status bits |
| irq_o | output | 1 | Interrupt request |
| rts_o | output | 1 | Ready to receive |

## Verification
The bench checks the FIFO count at mid-stop-bit. A receiver that pushed at the stop sample would show the byte too early there. It holds the line low well past a frame and clears the break status while the line is still low. A detector that re-armed without seeing the line go high would set the break status again. It also pushes one byte past a full FIFO and drains it: a FIFO that overwrote old data would return the wrong sequence, and one that dropped the overflow flag would hide the loss. It checks the timeout just before and just after its window, and again with the FIFO empty or the enable off, so a counter with the wrong unit, no restart or no gating gives a wrong result.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int OVS_W          = 4;   // 16 ticks per bit
    localparam int TOUT_UNIT_LOG2 = 7;   // 8 bits * 16 ticks
    localparam int NUM_SRC        = 6;
    localparam int SRC_FULL = 0;
    localparam int SRC_TOUT = 1;
    localparam int SRC_FRM  = 2;
    localparam int SRC_PAR  = 3;
    localparam int SRC_BRK  = 4;
    localparam int SRC_OVF  = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_DONE, ST_BRK
    } rx_state_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [DIV_W-1:0] baud_div_i,
    input  logic [1:0]       data_bits_i,
    input  logic             parity_en_i,
    input  logic             parity_odd_i,
    output logic             tick_o,
    output logic             busy_o,
    output logic             push_o,
    output logic [7:0]       data_o,
    output logic             frm_err_o,
    output logic             par_err_o,
    output logic             brk_o
);
    typedef struct packed {
        logic [1:0]       sync;
        logic [DIV_W-1:0] div;
        rx_state_e        st;
        logic [OVS_W-1:0] sub;
        logic [2:0]       bitn;
        logic [7:0]       shreg;
        logic             par;
        logic             zero;
        logic             frm;
        logic             perr;
        logic             push;
        logic             frm_ev;
        logic             par_ev;
        logic             brk_ev;
        logic [7:0]       data;
    } deser_s;

    deser_s q, d;
    logic   line, tick;
    logic [2:0] last_bit;

    assign line     = q.sync[1];
    assign tick     = (q.div == '0);
    assign last_bit = 3'(data_bits_i) + 3'd4;

    always_comb begin
        d        = q;
        d.sync   = {q.sync[0], line_i};
        d.div    = tick ? ((baud_div_i == '0) ? '0 : baud_div_i - 1'b1) : q.div - 1'b1;
        d.push   = 1'b0;
        d.frm_ev = 1'b0;
        d.par_ev = 1'b0;
        d.brk_ev = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (tick && !line) begin
                    d.st  = ST_START;
                    d.sub = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.sub == 4'd7) begin
                        if (line) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st   = ST_DATA;
                            d.sub  = '0;
                            d.bitn = '0;
                            d.zero = 1'b1;
                            d.par  = 1'b0;
                            d.perr = 1'b0;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.sub == 4'd15) begin
                        d.sub   = '0;
                        d.shreg = {line, q.shreg[7:1]};
                        d.par   = q.par ^ line;
                        d.zero  = q.zero & !line;
                        d.bitn  = q.bitn + 1'b1;
                        if (q.bitn == last_bit) begin
                            d.st = parity_en_i ? ST_PAR : ST_STOP;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (q.sub == 4'd15) begin
                        d.sub  = '0;
                        d.perr = (q.par ^ line) != parity_odd_i;
                        d.zero = q.zero & !line;
                        d.st   = ST_STOP;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.sub == 4'd15) begin
                        d.sub = '0;
                        if (!line && q.zero) begin
                            d.st     = ST_BRK;
                            d.brk_ev = 1'b1;
                        end else begin
                            d.frm = !line;
                            d.st  = ST_DONE;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                // wait out the second half of the stop bit before pushing
                if (tick) begin
                    if (q.sub == 4'd7) begin
                        d.st     = ST_IDLE;
                        d.push   = 1'b1;
                        d.data   = q.shreg >> (2'd3 - data_bits_i);
                        d.frm_ev = q.frm;
                        d.par_ev = q.perr;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            ST_BRK: begin
                if (line) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tick_o    = tick;
    assign busy_o    = (q.st != ST_IDLE);
    assign push_o    = q.push;
    assign data_o    = q.data;
    assign frm_err_o = q.frm_ev;
    assign par_err_o = q.par_ev;
    assign brk_o     = q.brk_ev;

    // a byte is only handed over once the receiver has left the frame
    assert_push_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> !busy_o) else $error("push while receiver busy");

    // one break event per low period
    assert_single_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |=> (!brk_o && !push_o)) else $error("repeated break event");
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [7:0]       data_i,
    input  logic             pop_i,
    output logic [7:0]       data_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             empty_o,
    output logic             ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_s;

    fifo_s q, d;
    logic [7:0] mem [DEPTH];
    logic full, empty, do_push, do_pop;

    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_pop  = pop_i && !empty && !clr_i;
    assign do_push = push_i && (!full || do_pop) && !clr_i;

    always_comb begin
        d     = q;
        d.ovf = push_i && full && !do_pop && !clr_i;
        if (clr_i) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) d.wr = (q.wr == PTR_W'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
            if (do_pop)  d.rd = (q.rd == PTR_W'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= data_i;
    end

    assign data_o  = mem[q.rd];
    assign cnt_o   = q.cnt;
    assign empty_o = empty;
    assign ovf_o   = q.ovf;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(DEPTH)) else $error("count above depth");

    assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && cnt_o == CNT_W'(DEPTH) && !pop_i && !clr_i) |=> ($stable(cnt_o) && ovf_o))
        else $error("full push not dropped");

    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)) else $error("reset did not empty fifo");
endmodule

// File: rtl/uart_rx_irq_ctrl.sv
module uart_rx_irq_ctrl
    import uart_rx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TOUT_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               busy_i,
    input  logic               push_i,
    input  logic               empty_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [CNT_W-1:0]   full_thr_i,
    input  logic [CNT_W-1:0]   flow_thr_i,
    input  logic               flow_en_i,
    input  logic [TOUT_W-1:0]  tout_thr_i,
    input  logic               tout_en_i,
    input  logic               frm_i,
    input  logic               par_i,
    input  logic               brk_i,
    input  logic               ovf_i,
    input  logic [NUM_SRC-1:0] int_ena_i,
    input  logic [NUM_SRC-1:0] int_clr_i,
    output logic [NUM_SRC-1:0] int_raw_o,
    output logic [NUM_SRC-1:0] int_st_o,
    output logic               irq_o,
    output logic               rts_o
);
    localparam int TC_W = TOUT_W + TOUT_UNIT_LOG2;

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
        logic [TC_W-1:0]    tcnt;
        logic               fired;
    } ctrl_s;

    ctrl_s q, d;
    logic [NUM_SRC-1:0] set;
    logic [TC_W-1:0]    target;
    logic               fire;

    assign target = {tout_thr_i, {TOUT_UNIT_LOG2{1'b0}}};

    always_comb begin
        d    = q;
        fire = 1'b0;
        if (push_i || empty_i) begin
            d.tcnt  = '0;
            d.fired = 1'b0;
        end else if (tick_i && !busy_i && !q.fired && tout_thr_i != '0) begin
            d.tcnt = q.tcnt + TC_W'(1);
            if (q.tcnt + TC_W'(1) == target) begin
                fire    = 1'b1;
                d.fired = 1'b1;
            end
        end
        set           = '0;
        set[SRC_FULL] = (full_thr_i != '0) && (cnt_i >= full_thr_i);
        set[SRC_TOUT] = fire && tout_en_i;
        set[SRC_FRM]  = frm_i;
        set[SRC_PAR]  = par_i;
        set[SRC_BRK]  = brk_i;
        set[SRC_OVF]  = ovf_i;
        d.raw = (q.raw & ~int_clr_i) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign int_raw_o = q.raw;
    assign int_st_o  = q.raw & int_ena_i;
    assign irq_o     = |int_st_o;
    assign rts_o     = !(flow_en_i && (cnt_i >= flow_thr_i));

    assert_tout_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_raw_o[SRC_TOUT]) |-> ($past(tout_en_i) && !$past(empty_i)))
        else $error("timeout without enable or data");

    assert_clear_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr_i[SRC_FRM] && !frm_i) |=> !int_raw_o[SRC_FRM])
        else $error("frame status not cleared");
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
    import uart_rx_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DIV_W  = 16,
    parameter int TOUT_W = 7,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rxd_i,
    input  logic               loopback_i,
    input  logic               lb_txd_i,
    input  logic [DIV_W-1:0]   baud_div_i,
    input  logic [1:0]         data_bits_i,
    input  logic               parity_en_i,
    input  logic               parity_odd_i,
    input  logic               fifo_rst_i,
    input  logic               rd_en_i,
    output logic [7:0]         rd_data_o,
    output logic [CNT_W-1:0]   fifo_cnt_o,
    input  logic [CNT_W-1:0]   full_thr_i,
    input  logic               flow_en_i,
    input  logic [CNT_W-1:0]   flow_thr_i,
    input  logic               tout_en_i,
    input  logic [TOUT_W-1:0]  tout_thr_i,
    input  logic [NUM_SRC-1:0] int_ena_i,
    input  logic [NUM_SRC-1:0] int_clr_i,
    output logic [NUM_SRC-1:0] int_raw_o,
    output logic [NUM_SRC-1:0] int_st_o,
    output logic               irq_o,
    output logic               rts_o
);
    logic       line, tick, busy, push, frm, par, brk, ovf, empty;
    logic [7:0] rx_byte;

    assign line = loopback_i ? lb_txd_i : rxd_i;

    uart_rx_deser #(.DIV_W(DIV_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .line_i(line), .baud_div_i(baud_div_i),
        .data_bits_i(data_bits_i), .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
        .tick_o(tick), .busy_o(busy), .push_o(push), .data_o(rx_byte),
        .frm_err_o(frm), .par_err_o(par), .brk_o(brk)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr_i(fifo_rst_i), .push_i(push), .data_i(rx_byte),
        .pop_i(rd_en_i), .data_o(rd_data_o), .cnt_o(fifo_cnt_o), .empty_o(empty), .ovf_o(ovf)
    );

    uart_rx_irq_ctrl #(.CNT_W(CNT_W), .TOUT_W(TOUT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .busy_i(busy), .push_i(push),
        .empty_i(empty), .cnt_i(fifo_cnt_o), .full_thr_i(full_thr_i), .flow_thr_i(flow_thr_i),
        .flow_en_i(flow_en_i), .tout_thr_i(tout_thr_i), .tout_en_i(tout_en_i),
        .frm_i(frm), .par_i(par), .brk_i(brk), .ovf_i(ovf), .int_ena_i(int_ena_i),
        .int_clr_i(int_clr_i), .int_raw_o(int_raw_o), .int_st_o(int_st_o),
        .irq_o(irq_o), .rts_o(rts_o)
    );
endmodule

// File: tb/tb_uart_rx_irq.sv
`timescale 1ns/1ps
module tb_uart_rx_irq;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int BITC  = 64;   // baud_div 4 * 16 ticks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_v = 1'b1, lb_mode = 1'b0;
    logic rxd, lb_txd;
    logic [15:0] baud_div = 16'd4;
    logic [1:0]  nb_code = 2'd3;
    logic pen = 1'b0, podd = 1'b0, fifo_rst = 1'b0, rd_en = 1'b0;
    logic [CW-1:0] full_thr = '0, flow_thr = '0;
    logic flow_en = 1'b0, tout_en = 1'b0;
    logic [6:0] tout_thr = '0;
    logic [5:0] int_ena = '0, int_clr = '0;
    logic [7:0] rd_data;
    logic [CW-1:0] cnt;
    logic [5:0] raw, st;
    logic irq, rts;
    int checks = 0, fails = 0, mid_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;
    assign rxd    = lb_mode ? 1'b0 : line_v;
    assign lb_txd = lb_mode ? line_v : 1'b1;

    uart_rx_irq #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .loopback_i(lb_mode), .lb_txd_i(lb_txd),
        .baud_div_i(baud_div), .data_bits_i(nb_code), .parity_en_i(pen), .parity_odd_i(podd),
        .fifo_rst_i(fifo_rst), .rd_en_i(rd_en), .rd_data_o(rd_data), .fifo_cnt_o(cnt),
        .full_thr_i(full_thr), .flow_en_i(flow_en), .flow_thr_i(flow_thr),
        .tout_en_i(tout_en), .tout_thr_i(tout_thr), .int_ena_i(int_ena), .int_clr_i(int_clr),
        .int_raw_o(raw), .int_st_o(st), .irq_o(irq), .rts_o(rts)
    );

    function automatic logic [7:0] mask_of(logic [1:0] code);
        return 8'hFF >> (3 - code);
    endfunction

    function automatic logic par_of(logic [7:0] d, logic [1:0] code, logic odd);
        return (^(d & mask_of(code))) ^ odd;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [7:0] d, bit flip_par, logic stop_lvl);
        @(negedge clk);
        line_v = 1'b0;
        wait_clk(BITC);
        for (int i = 0; i < 5 + int'(nb_code); i++) begin
            line_v = d[i];
            wait_clk(BITC);
        end
        if (pen) begin
            line_v = par_of(d, nb_code, podd) ^ flip_par;
            wait_clk(BITC);
        end
        line_v = stop_lvl;
        wait_clk(48);
        mid_cnt = int'(cnt);
        wait_clk(16);
        line_v = 1'b1;
    endtask

    task automatic pop(string req, logic [7:0] exp);
        @(negedge clk);
        chk(req, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear(logic [5:0] m);
        @(negedge clk);
        int_clr = m;
        @(negedge clk);
        int_clr = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] d;
        bit bad;
        seed = $urandom(1234);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R11 reset count", int'(cnt), 0);
        chk("R9 reset raw", int'(raw), 0);
        chk("R9 reset irq", int'(irq), 0);
        chk("R10 reset rts", int'(rts), 1);

        // R1: short low glitch is not a start bit
        @(negedge clk);
        line_v = 1'b0;
        wait_clk(16);
        line_v = 1'b1;
        wait_clk(200);
        chk("R1 glitch ignored", int'(cnt), 0);
        chk("R7 glitch no frame err", int'(raw[2]), 0);

        // R1 R2 R6: random formats
        for (int k = 0; k < 16; k++) begin
            nb_code = 2'($urandom % 4);
            pen     = 1'($urandom % 2);
            podd    = 1'($urandom % 2);
            d       = 8'($urandom);
            bad     = pen && ($urandom % 3 == 0);
            send(d, bad, 1'b1);
            wait_clk(24);
            chk("R2 count held at mid-stop", mid_cnt, 0);
            chk("R2 count after stop", int'(cnt), 1);
            chk("R6 parity status", int'(raw[3]), int'(bad));
            pop("R1 data", d & mask_of(nb_code));
            clear(6'h3F);
        end
        nb_code = 2'd3;
        pen = 1'b0;

        // R7 R9: frame error with enable mask
        int_ena = 6'b000100;
        send(8'h55, 1'b0, 1'b0);
        wait_clk(24);
        chk("R7 frame status", int'(raw[2]), 1);
        chk("R7 not break", int'(raw[4]), 0);
        chk("R9 masked status", int'(st), 4);
        chk("R9 irq", int'(irq), 1);
        pop("R7 byte kept", 8'h55);
        clear(6'b000100);
        chk("R9 w1c clears", int'(raw[2]), 0);
        chk("R9 irq drops", int'(irq), 0);
        int_ena = '0;

        // R8: break, single event until line high
        @(negedge clk);
        line_v = 1'b0;
        wait_clk(12 * BITC);
        chk("R8 break status", int'(raw[4]), 1);
        chk("R8 no byte", int'(cnt), 0);
        chk("R8 no frame err", int'(raw[2]), 0);
        clear(6'b010000);
        wait_clk(5 * BITC);
        chk("R8 one event per low period", int'(raw[4]), 0);
        line_v = 1'b1;
        wait_clk(2 * BITC);
        send(8'hA5, 1'b0, 1'b1);
        wait_clk(24);
        pop("R8 recovers", 8'hA5);

        // R4 R10 R3: thresholds and overflow
        full_thr = CW'(3);
        flow_thr = CW'(5);
        flow_en  = 1'b1;
        for (int k = 1; k <= DEPTH; k++) begin
            send(8'(k * 17 + 3), 1'b0, 1'b1);
            wait_clk(24);
            chk("R4 threshold status", int'(raw[0]), int'(k >= 3));
            chk("R10 rts", int'(rts), int'(k < 5));
        end
        clear(6'b000001);
        chk("R4 clear while above level", int'(raw[0]), 1);
        send(8'hEE, 1'b0, 1'b1);
        wait_clk(24);
        chk("R3 count stays full", int'(cnt), DEPTH);
        chk("R3 overflow status", int'(raw[5]), 1);
        for (int k = 1; k <= DEPTH; k++) pop("R3 R11 order kept", 8'(k * 17 + 3));
        clear(6'h3F);
        chk("R4 clear after drain", int'(raw[0]), 0);
        chk("R10 rts after drain", int'(rts), 1);
        full_thr = '0;
        flow_en  = 1'b0;

        // R11: fifo reset
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        wait_clk(24);
        chk("R11 two stored", int'(cnt), 2);
        @(negedge clk);
        fifo_rst = 1'b1;
        @(negedge clk);
        fifo_rst = 1'b0;
        @(negedge clk);
        chk("R11 reset empties", int'(cnt), 0);
        send(8'h3C, 1'b0, 1'b1);
        wait_clk(24);
        pop("R11 works after reset", 8'h3C);

        // R5: idle timeout, 2 units = 1024 clocks
        tout_thr = 7'd2;
        tout_en  = 1'b1;
        send(8'h5A, 1'b0, 1'b1);
        wait_clk(900);
        chk("R5 not before window", int'(raw[1]), 0);
        wait_clk(200);
        chk("R5 after window", int'(raw[1]), 1);
        pop("R5 byte", 8'h5A);
        clear(6'h3F);
        wait_clk(1200);
        chk("R5 empty fifo no timeout", int'(raw[1]), 0);
        tout_en = 1'b0;
        send(8'h6B, 1'b0, 1'b1);
        wait_clk(1200);
        chk("R5 disabled no timeout", int'(raw[1]), 0);
        pop("R5 byte disabled", 8'h6B);
        clear(6'h3F);

        // R12: loopback, external line held low
        lb_mode = 1'b1;
        wait_clk(BITC);
        send(8'h96, 1'b0, 1'b1);
        wait_clk(24);
        chk("R12 one byte", int'(cnt), 1);
        pop("R12 loopback data", 8'h96);
        chk("R12 external low ignored", int'(raw[4]), 0);
        lb_mode = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule